// File: doc/BRIEF.md
# E3 Frame Parity Error Monitor

This receive-side monitor watches a byte-wide E3 stream that has already been framed. Each accepted byte comes with a frame-start marker and a flag for the error-monitoring (EM) overhead byte. The block XORs all bytes of each complete frame into an 8-bit interleaved parity value (BIP-8). It then checks that value against the EM byte carried by the frame that follows. A mismatch is an errored frame: it sets a sticky status bit, increments a saturating error counter and can drive an active-low interrupt.

A single status register collects the parity error and five defect events that other overhead detectors supply. A host read returns the latched bits and clears them. A per-bit enable mask selects which status bits may pull the interrupt low.

A three-state controller decides when a parity reference exists:

- `S_HUNT` is the state with no frame sync. On a frame-start byte with sync high, the transition HUNT→FILL is taken.
- `S_FILL` accumulates the first frame, which has no reference. The next frame-start byte gives the transition FILL→CHECK, and that byte stores the reference.
- `S_CHECK` is the state in which every EM byte is compared.
- Loss of sync gives the transition FILL→HUNT or CHECK→HUNT.

Top module: `e3bip_mon`

## Requirements
- R1: The parity of a frame is the XOR of every accepted byte from its frame-start byte up to the byte before the next frame-start byte, including its own EM byte.
- R2: The EM byte of frame N+1 is compared with the parity of frame N. Equal values count as an error-free frame and change neither `err_cnt` nor status bit 2.
- R3: On a mismatch, status bit 2 is set and `err_cnt` increments by one, both visible after the clock edge that accepts the EM byte.
- R4: No comparison is made for the first frame after reset or after `in_sync` rises. While `in_sync` is low the controller returns to hunting and discards the stored reference.
- R5: Status layout:
  - bit 0 is set by `side_evt[0]` (payload label mismatch).
  - bit 1 is set by `side_evt[1]` (framing byte error).
  - bit 2 is the parity error.
  - bit 3 is set by `side_evt[2]` (change in remote defect).
  - bit 4 is set by `side_evt[3]` (remote error event).
  - bit 6 is set by `side_evt[4]` (change in trace message).
  - bits 5 and 7 always read 0.
- R6: Status bits stay set until read. A cycle with `rd_stb` high copies the status into `rd_data` and clears it, both visible after that edge.
- R7: An event in the same cycle as a read stays set for the next read and is absent from the current `rd_data`.
- R8: `irq_n` is 0 while any status bit is 1 whose enable bit (written via `en_wr`/`en_wdata`, reset 0) is 1, and 1 otherwise.
- R9: `err_cnt` saturates at 2^CNT_W−1 (15 by default).
- R10: After reset, `err_cnt`, the status, `rd_data` and the enables are 0, `irq_n` is 1 and the controller is hunting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_sync | input | 1 | Frame sync held by the upstream framer |
| in_valid | input | 1 | Byte accepted this cycle |
| in_sof | input | 1 | Accepted byte is the first of a frame |
| in_em | input | 1 | Accepted byte is the EM byte |
| in_data | input | DW | Received byte |
| side_evt | input | 5 | One-cycle defect events from other detectors |
| rd_stb | input | 1 | Host read of the status register |
| rd_data | output | 8 | Status value captured by the last read |
| en_wr | input | 1 | Write strobe for the enable mask |
| en_wdata | input | 8 | Enable mask value |
| irq_n | output | 1 | Active-low interrupt |
| err_cnt | output | CNT_W | Saturating count of errored frames |

## Verification
The assertions assume that the EM flag never falls on a frame-start byte. They also assume that defect events and host accesses are single-cycle strobes, which the counter and sticky-bit properties rely on. The stimulus keeps within these limits by sending 10-byte frames with the EM byte fixed at position 3 and a one-cycle gap after each frame. It drives reads, enable writes and event pulses for exactly one cycle, and only between frames. Loss of sync is applied between bytes of a frame, before its EM byte.

// File: rtl/e3bip_pkg.sv
`timescale 1ns/1ps
package e3bip_pkg;
    typedef enum logic [1:0] {
        S_HUNT  = 2'd0,
        S_FILL  = 2'd1,
        S_CHECK = 2'd2
    } mon_state_e;

    localparam int STAT_W      = 8;
    localparam int SIDE_W      = 5;
    localparam int B_LABEL     = 0;
    localparam int B_FRAMING   = 1;
    localparam int B_PARITY    = 2;
    localparam int B_REMOTE_DF = 3;
    localparam int B_REMOTE_ER = 4;
    localparam int B_TRACE     = 6;
endpackage

// File: rtl/e3bip_acc.sv
`timescale 1ns/1ps
module e3bip_acc #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_en,
    input  logic          sof,
    input  logic          capture,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] ref_q
);
    logic [DW-1:0] acc_q;

    // running XOR restarts on each frame-start byte; the finished value
    // of the previous frame is kept as the reference for the next EM byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            ref_q <= '0;
        end else if (byte_en) begin
            acc_q <= sof ? din : (acc_q ^ din);
            if (sof && capture) ref_q <= acc_q;
        end
    end
endmodule

// File: rtl/e3bip_stat.sv
`timescale 1ns/1ps
module e3bip_stat #(
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] set_vec,
    input  logic          rd_stb,
    input  logic          en_wr,
    input  logic [SW-1:0] en_wdata,
    output logic [SW-1:0] rd_data,
    output logic [SW-1:0] status_q,
    output logic          irq_n
);
    logic [SW-1:0] en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            rd_data  <= '0;
            en_q     <= '0;
        end else begin
            // reported bits clear; new events of this cycle survive
            status_q <= (rd_stb ? '0 : status_q) | set_vec;
            if (rd_stb) rd_data <= status_q;
            if (en_wr)  en_q    <= en_wdata;
        end
    end

    assign irq_n = ~|(status_q & en_q);
endmodule

// File: rtl/e3bip_cnt.sv
`timescale 1ns/1ps
module e3bip_cnt #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt <= '0;
        else if (inc && cnt != CMAX) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/e3bip_mon.sv
`timescale 1ns/1ps
module e3bip_mon
    import e3bip_pkg::*;
#(
    parameter int DW    = 8,
    parameter int CNT_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_sync,
    input  logic                 in_valid,
    input  logic                 in_sof,
    input  logic                 in_em,
    input  logic [DW-1:0]        in_data,
    input  logic [SIDE_W-1:0]    side_evt,
    input  logic                 rd_stb,
    output logic [STAT_W-1:0]    rd_data,
    input  logic                 en_wr,
    input  logic [STAT_W-1:0]    en_wdata,
    output logic                 irq_n,
    output logic [CNT_W-1:0]     err_cnt
);
    mon_state_e        state_q, state_d;
    logic              capture, cmp_en, mismatch;
    logic [DW-1:0]     ref_w;
    logic [STAT_W-1:0] set_vec, stat_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_HUNT;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_HUNT:  if (in_sync && in_valid && in_sof) state_d = S_FILL;
            S_FILL:  if (!in_sync)                      state_d = S_HUNT;
                     else if (in_valid && in_sof)       state_d = S_CHECK;
            S_CHECK: if (!in_sync)                      state_d = S_HUNT;
            default:                                    state_d = S_HUNT;
        endcase
    end

    // state-decoded controls
    always_comb begin
        capture = (state_q != S_HUNT);
        cmp_en  = (state_q == S_CHECK) && in_sync && in_valid && in_em && !in_sof;
    end

    e3bip_acc #(.DW(DW)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .byte_en (in_valid),
        .sof     (in_sof),
        .capture (capture),
        .din     (in_data),
        .ref_q   (ref_w)
    );

    assign mismatch = cmp_en && (in_data != ref_w);

    always_comb begin
        set_vec              = '0;
        set_vec[B_LABEL]     = side_evt[0];
        set_vec[B_FRAMING]   = side_evt[1];
        set_vec[B_PARITY]    = mismatch;
        set_vec[B_REMOTE_DF] = side_evt[2];
        set_vec[B_REMOTE_ER] = side_evt[3];
        set_vec[B_TRACE]     = side_evt[4];
    end

    e3bip_stat #(.SW(STAT_W)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .rd_stb   (rd_stb),
        .en_wr    (en_wr),
        .en_wdata (en_wdata),
        .rd_data  (rd_data),
        .status_q (stat_q),
        .irq_n    (irq_n)
    );

    e3bip_cnt #(.CW(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (mismatch),
        .cnt   (err_cnt)
    );
endmodule

// File: rtl/e3bip_chk.sv
`timescale 1ns/1ps
module e3bip_chk
    import e3bip_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_sync,
    input logic              rd_stb,
    input logic              en_wr,
    input logic              irq_n,
    input logic [CNT_W-1:0]  err_cnt,
    input logic [STAT_W-1:0] rd_data,
    input logic [STAT_W-1:0] status_q,
    input mon_state_e        state_q
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (err_cnt == $past(err_cnt)) || (err_cnt == $past(err_cnt) + 1'b1));

    p_no_cmp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_CHECK) |=> $stable(err_cnt));

    p_hunt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !in_sync |=> (state_q == S_HUNT));

    p_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> (rd_data == $past(status_q)));

    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[B_PARITY] && !rd_stb) |=> status_q[B_PARITY]);

    p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && !rd_stb && !en_wr) |=> !irq_n);

    p_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_cnt == CMAX) |=> (err_cnt == CMAX));
endmodule

bind e3bip_mon e3bip_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_sync  (in_sync),
    .rd_stb   (rd_stb),
    .en_wr    (en_wr),
    .irq_n    (irq_n),
    .err_cnt  (err_cnt),
    .rd_data  (rd_data),
    .status_q (stat_q),
    .state_q  (state_q)
);

// File: tb/tb_e3bip_mon.sv
`timescale 1ns/1ps
module tb_e3bip_mon;
    localparam int CNT_W  = 4;
    localparam int CMAX   = (1 << CNT_W) - 1;
    localparam int FLEN   = 10;
    localparam int EM_POS = 3;

    logic       clk = 1'b0;
    logic       rst_n, in_sync, in_valid, in_sof, in_em, rd_stb, en_wr;
    logic [7:0] in_data, en_wdata, rd_data;
    logic [4:0] side_evt;
    logic       irq_n;
    logic [CNT_W-1:0] err_cnt;

    int         n_chk = 0, n_err = 0;
    int         exp_q[$];
    logic       mon_tag = 1'b0;
    logic [7:0] tx_prev = 8'h00, rx_prev = 8'h00, en_model = 8'h00, v;
    bit         have_ref = 1'b0;
    int         model_cnt = 0;

    always #10 clk = ~clk;

    e3bip_mon #(.DW(8), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .in_sync(in_sync), .in_valid(in_valid),
        .in_sof(in_sof), .in_em(in_em), .in_data(in_data), .side_evt(side_evt),
        .rd_stb(rd_stb), .rd_data(rd_data), .en_wr(en_wr), .en_wdata(en_wdata),
        .irq_n(irq_n), .err_cnt(err_cnt)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    // driver: sends one frame and pushes the expected comparison outcome
    // item codes: 0 match, 1 mismatch, 2 no comparison
    task automatic send_frame(input int fidx, input int flip_pos,
                              input logic [7:0] flip_mask, input logic [7:0] em_extra);
        logic [7:0] b, cpar, rpar, em_val;
        em_val = tx_prev ^ em_extra;
        cpar = 8'h00;
        rpar = 8'h00;
        for (int i = 0; i < FLEN; i++) begin
            b = (i == EM_POS) ? em_val : 8'(fidx * 29 + i * 53 + 7);
            cpar ^= b;
            if (i == flip_pos) b ^= flip_mask;
            rpar ^= b;
            @(negedge clk);
            in_valid = 1'b1;
            in_sof   = (i == 0);
            in_em    = (i == EM_POS);
            in_data  = b;
            if (i == EM_POS) begin
                exp_q.push_back(have_ref ? ((rx_prev != em_val) ? 1 : 0) : 2);
                mon_tag = 1'b1;
            end else begin
                mon_tag = 1'b0;
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_em = 1'b0; mon_tag = 1'b0;
        tx_prev  = cpar;
        rx_prev  = rpar;
        have_ref = 1'b1;
    endtask

    task automatic do_read(output logic [7:0] val);
        @(negedge clk); rd_stb = 1'b1;
        @(negedge clk); rd_stb = 1'b0;
        val = rd_data;
    endtask

    task automatic set_en(input logic [7:0] m);
        @(negedge clk); en_wr = 1'b1; en_wdata = m;
        @(negedge clk); en_wr = 1'b0;
        en_model = m;
    endtask

    task automatic pulse_side(input logic [4:0] e);
        @(negedge clk); side_evt = e;
        @(negedge clk); side_evt = 5'b0;
    endtask

    // monitor: pops an expected outcome for every EM byte the driver sent
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (mon_tag) begin
                int e, nexp;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2", "scoreboard empty", 0, 1);
                end else begin
                    e = exp_q.pop_front();
                    nexp = model_cnt + ((e == 1) ? 1 : 0);
                    if (nexp > CMAX) nexp = CMAX;
                    if (e == 2)
                        chk(int'(err_cnt) == nexp, "R4", "uncompared frame err_cnt", int'(err_cnt), nexp);
                    else if (model_cnt == CMAX)
                        chk(int'(err_cnt) == nexp, "R9", "saturated err_cnt", int'(err_cnt), nexp);
                    else
                        chk(int'(err_cnt) == nexp, "R1 R2 R3", "err_cnt after EM byte", int'(err_cnt), nexp);
                    if (e == 1 && en_model[2])
                        chk(irq_n == 1'b0, "R8", "irq_n on parity error", int'(irq_n), 0);
                    model_cnt = nexp;
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL R10 watchdog: actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_sync = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_em = 1'b0;
        in_data = 8'h00; side_evt = 5'b0; rd_stb = 1'b0; en_wr = 1'b0; en_wdata = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(err_cnt == '0, "R10", "err_cnt after reset", int'(err_cnt), 0);
        chk(irq_n == 1'b1, "R10", "irq_n after reset", int'(irq_n), 1);
        chk(rd_data == 8'h00, "R10", "rd_data after reset", int'(rd_data), 0);
        do_read(v);
        chk(v == 8'h00, "R10", "status after reset", int'(v), 0);

        set_en(8'h04);
        in_sync = 1'b1;
        // first frame: no comparison (R4); then clean frames (R1 R2)
        send_frame(0, -1, 8'h00, 8'h00);
        send_frame(1, -1, 8'h00, 8'h00);
        send_frame(2, -1, 8'h00, 8'h00);
        send_frame(3, -1, 8'h00, 8'h00);
        // single-bit error in frame 4 fails only frame 5's comparison (R3)
        send_frame(4, 6, 8'h10, 8'h00);
        send_frame(5, -1, 8'h00, 8'h00);
        send_frame(6, -1, 8'h00, 8'h00);

        do_read(v);
        chk(v == 8'h04, "R3 R6", "status read after error", int'(v), 8'h04);
        do_read(v);
        chk(v == 8'h00, "R6", "status cleared by read", int'(v), 0);
        chk(irq_n == 1'b1, "R8", "irq_n after clear", int'(irq_n), 1);

        // R5 side events land in their bits; masked so no interrupt (R8)
        pulse_side(5'b11111);
        chk(irq_n == 1'b1, "R8", "irq_n with masked bits", int'(irq_n), 1);
        do_read(v);
        chk(v == 8'h5B, "R5", "side event layout", int'(v), 8'h5B);

        // R7 event in the read cycle survives
        @(negedge clk); rd_stb = 1'b1; side_evt = 5'b00010;
        @(negedge clk); rd_stb = 1'b0; side_evt = 5'b0;
        chk(rd_data == 8'h00, "R7", "read during event", int'(rd_data), 0);
        do_read(v);
        chk(v == 8'h02, "R7", "event kept after read", int'(v), 8'h02);

        // R8 enabled bit drives the interrupt
        set_en(8'h40);
        pulse_side(5'b10000);
        chk(irq_n == 1'b0, "R8", "irq_n enabled bit", int'(irq_n), 0);
        do_read(v);
        chk(v == 8'h40, "R5", "trace bit position", int'(v), 8'h40);
        chk(irq_n == 1'b1, "R8", "irq_n after read", int'(irq_n), 1);

        // R4 loss of sync mid-frame, then first frame has a bad EM but is not compared
        set_en(8'h04);
        @(negedge clk); in_valid = 1'b1; in_sof = 1'b1; in_data = 8'h3C;
        @(negedge clk); in_sof = 1'b0; in_data = 8'hC3;
        @(negedge clk); in_valid = 1'b0; in_sync = 1'b0;
        repeat (3) @(negedge clk);
        in_sync = 1'b1;
        have_ref = 1'b0;
        send_frame(20, -1, 8'h00, 8'h5A);
        send_frame(21, -1, 8'h00, 8'h00);
        chk(int'(err_cnt) == 1, "R4", "err_cnt after resync", int'(err_cnt), 1);

        // R9 saturation: every frame carries an error
        for (int k = 0; k < 17; k++) send_frame(30 + k, 7, 8'h01, 8'h00);
        send_frame(60, -1, 8'h00, 8'h00);
        chk(int'(err_cnt) == CMAX, "R9", "err_cnt saturated", int'(err_cnt), CMAX);

        repeat (2) @(negedge clk);
        summary();
        $finish;
    end
endmodule